// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small non-volatile word store of 64 words by 16 bits that a host reaches over three wires: a select line, a shift clock and a serial data input. A fourth pin, the serial data output, comes with a drive-enable so that the chip-level pad can tri-state it. All pins are sampled in the system clock domain through a synchronizer, and bits are taken on rising edges of the shift clock. A frame opens when select goes high. It carries a start bit of 1, a 2-bit command code and a 6-bit word address. Write frames then carry 16 data bits.

Read has no side effects and is accepted in any enable state. The four commands that change the store (single-word write, single-word erase, whole-array write and whole-array erase) run only after an enable command. Each one starts a self-timed programming cycle whose length is a parameter counted in system clock cycles, so a simulation can use a short value. While the cycle runs, the data output reports the busy/ready state each time the host selects the block again after a long enough low interval.

Top module: `ee_serial_rom`

## Requirements
- R1: While select is high, the block ignores 0 bits until it sees a 1, which it takes as the start bit. It then shifts in 8 bits, MSB first: a 2-bit command code followed by a 6-bit address. Each bit is taken at a rising edge of the shift clock.
- R2: Command code 10 is a read. After the rising edge that carries the last address bit, the output drives a single 0. The next 16 rising edges then present the addressed word, MSB first. Read works whether writes are enabled or disabled, and after reset every word reads 0xFFFF.
- R3: After reset, writes are disabled. While disabled, codes 01 and 11 and the whole-array variants leave the store unchanged and start no programming cycle, so no status is shown on a later select.
- R4: Code 00 with address bits [5:4] = 11 enables writes and with [5:4] = 00 disables them. The enable holds across any number of programming cycles until a disable command or a reset.
- R5: Code 01 is a word write. It carries 16 data bits, MSB first, after the address. Programming starts only after the 16th data bit.
- R6: Code 11 sets the addressed word to 0xFFFF. Code 00 with [5:4] = 10 sets every word to 0xFFFF. Both start programming as soon as the header is decoded.
- R7: Code 00 with [5:4] = 01 carries 16 data bits and writes them to every word.
- R8: A programming cycle lasts PROG_CYCLES system clocks. After it starts, whenever select rises after at least CS_LOW_MIN system clocks low, the output drives 0 while the cycle is busy and 1 once it is done. A 1 clocked in while ready ends the status display and serves as the start bit of a new frame.
- R9: While status is pending, a select high that follows a low interval shorter than CS_LOW_MIN leaves the output undriven until the next deselect.
- R10: Shift-clock activity during a programming cycle has no effect, so commands sent while busy are lost.
- R11: Select falling before a frame completes leaves the store and the enable state as they were.
- R12: The output is undriven while select is low and while header or write data bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, frame active when high |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (read bits or ready status) |
| sdo_oe | output | 1 | Drive enable for sdo; low means high impedance |

## Verification
The hardest situation to reach is a complete, well-formed write frame arriving while a programming cycle is still running. This needs a long cycle, a fresh select with a valid low interval that enters the status display, and a full frame clocked in before the timer expires. The bench does this on purpose. It sets the cycle length so that a whole 25-bit frame fits inside one busy window, then reads the word back afterwards to show the late frame left no mark. A short-low reselect inside the same window also covers the rule on the minimum low interval.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial EEPROM slave.
// Assumes a fixed 64 x 16 organisation; the command codes are the wire encoding.
package ee_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 6;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int CMD_W  = 2 + ADDR_W;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_CLEAR  = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HUNT, ST_CMD, ST_WDATA, ST_READ, ST_STATUS, ST_SKIP
    } fsm_state_e;

    typedef struct packed {
        logic              all;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } prog_req_t;
endpackage

// File: rtl/ee_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the asynchronous serial pins.
// Assumes inputs change slowly relative to clk; reset value is all zeros.
module ee_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: move the pin vector one flop closer to the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n)      stage_q[g] <= '0;
            else if (g == 0) stage_q[g] <= din;
            else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ee_prog_timer.sv
`timescale 1ns/1ps
// Self-timed programming cycle: busy for exactly CYCLES clocks after start.
// Assumes start never arrives while busy (the command FSM guarantees this).
module ee_prog_timer #(
    parameter int CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Purpose: load the cycle length on start and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);

    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/ee_cmd_fsm.sv
`timescale 1ns/1ps
// Frame decoder for the serial EEPROM: hunts the start bit, decodes the
// command header, shifts write data, serialises read data and shows status.
// Assumes synchronized pins; sclk rising edges are detected here.
module ee_cmd_fsm
    import ee_pkg::*;
#(
    parameter int CS_LOW_MIN = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output prog_req_t         prog_req,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int LW    = $clog2(CS_LOW_MIN + 1);
    localparam int CNT_W = $clog2(WORD_W + 1);

    fsm_state_e        state;
    logic              sclk_q, rise;
    logic [CMD_W-2:0]  shreg;
    logic [CMD_W-1:0]  hdr_w;
    logic [1:0]        op, sub;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] rd_sh;
    logic              sdo_q, wen_q, stat_pend;
    logic [LW-1:0]     low_cnt;

    assign rise    = sclk_s & ~sclk_q;
    assign hdr_w   = {shreg, sdi_s};
    assign rd_addr = hdr_w[ADDR_W-1:0];
    assign op      = hdr_w[CMD_W-1 -: 2];
    assign sub     = hdr_w[ADDR_W-1 -: 2];

    // Purpose: sequence one frame per select-high period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sclk_q     <= 1'b0;
            shreg      <= '0;
            cnt        <= '0;
            rd_sh      <= '0;
            sdo_q      <= 1'b0;
            wen_q      <= 1'b0;
            stat_pend  <= 1'b0;
            low_cnt    <= '0;
            prog_start <= 1'b0;
            prog_req   <= '0;
        end else begin
            sclk_q     <= sclk_s;
            prog_start <= 1'b0;
            if (!sel_s && low_cnt != LW'(CS_LOW_MIN)) low_cnt <= low_cnt + 1'b1;
            if (!sel_s) begin
                state <= ST_IDLE;
                if (state == ST_STATUS && !busy) stat_pend <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        low_cnt <= '0;
                        cnt     <= '0;
                        if (stat_pend)
                            state <= (low_cnt == LW'(CS_LOW_MIN)) ? ST_STATUS : ST_SKIP;
                        else
                            state <= ST_HUNT;
                    end
                    ST_HUNT: if (rise && sdi_s) begin
                        state <= ST_CMD;
                        cnt   <= '0;
                    end
                    ST_STATUS: if (rise && sdi_s && !busy) begin
                        stat_pend <= 1'b0;
                        state     <= ST_CMD;
                        cnt       <= '0;
                    end
                    ST_CMD: if (rise) begin
                        shreg <= hdr_w[CMD_W-2:0];
                        cnt   <= cnt + 1'b1;
                        if (cnt == CNT_W'(CMD_W - 1)) begin
                            cnt   <= '0;
                            state <= ST_SKIP;
                            case (op)
                                OP_READ: begin
                                    rd_sh <= rd_word;
                                    sdo_q <= 1'b0;
                                    state <= ST_READ;
                                end
                                OP_WRITE: begin
                                    prog_req.all  <= 1'b0;
                                    prog_req.addr <= rd_addr;
                                    state         <= ST_WDATA;
                                end
                                OP_ERASE: begin
                                    prog_req <= '{all: 1'b0, addr: rd_addr, data: '1};
                                    if (wen_q) begin
                                        prog_start <= 1'b1;
                                        stat_pend  <= 1'b1;
                                    end
                                end
                                default: begin
                                    case (sub)
                                        SUB_UNLOCK: wen_q <= 1'b1;
                                        SUB_LOCK:   wen_q <= 1'b0;
                                        SUB_CLEAR: begin
                                            prog_req <= '{all: 1'b1, addr: '0, data: '1};
                                            if (wen_q) begin
                                                prog_start <= 1'b1;
                                                stat_pend  <= 1'b1;
                                            end
                                        end
                                        default: begin
                                            prog_req.all <= 1'b1;
                                            state        <= ST_WDATA;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_WDATA: if (rise) begin
                        prog_req.data <= {prog_req.data[WORD_W-2:0], sdi_s};
                        cnt           <= cnt + 1'b1;
                        if (cnt == CNT_W'(WORD_W - 1)) begin
                            state <= ST_SKIP;
                            if (wen_q) begin
                                prog_start <= 1'b1;
                                stat_pend  <= 1'b1;
                            end
                        end
                    end
                    ST_READ: if (rise) begin
                        if (cnt == CNT_W'(WORD_W)) begin
                            state <= ST_SKIP;
                        end else begin
                            sdo_q <= rd_sh[WORD_W-1];
                            rd_sh <= {rd_sh[WORD_W-2:0], 1'b0};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: drive read bits or ready status; undriven in every other phase.
    assign sdo    = (state == ST_STATUS) ? ~busy : sdo_q;
    assign sdo_oe = (state == ST_READ) || (state == ST_STATUS);
endmodule

// File: rtl/ee_serial_rom.sv
`timescale 1ns/1ps
// Top of the three-wire serial EEPROM slave: synchronizer, frame FSM,
// programming timer and the 64 x 16 register array.
// Assumes the shift clock is several times slower than clk.
module ee_serial_rom
    import ee_pkg::*;
#(
    parameter int PROG_CYCLES = 2000000,
    parameter int CS_LOW_MIN  = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic [2:0]        sync_v;
    logic              sel_s, sclk_s, sdi_s;
    logic              prog_start, busy, done;
    prog_req_t         prog_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] mem [WORDS];

    ee_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({sel, sclk, sdi}), .dout(sync_v)
    );
    assign {sel_s, sclk_s, sdi_s} = sync_v;

    ee_cmd_fsm #(.CS_LOW_MIN(CS_LOW_MIN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr),
        .prog_start(prog_start), .prog_req(prog_req), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(done)
    );

    assign rd_word = mem[rd_addr];

    // Purpose: commit the pending word or whole-array update when the cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (done) begin
            if (prog_req.all) begin
                for (int i = 0; i < WORDS; i++) mem[i] <= prog_req.data;
            end else begin
                mem[prog_req.addr] <= prog_req.data;
            end
        end
    end

    a_r10_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy);
    a_r11_no_start_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |-> !prog_start);
    a_r12_quiet_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !sdo_oe);
endmodule

// File: tb/ee_serial_rom_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected words, a monitor compares
// the captured dummy+data streams as they arrive.
module ee_serial_rom_tb_top;
    localparam int PROG = 1000;
    localparam int LOWM = 20;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;

    always #2.5 clk = ~clk;

    ee_serial_rom #(.PROG_CYCLES(PROG), .CS_LOW_MIN(LOWM)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    typedef struct { logic [15:0] v; string tag; } exp_t;
    exp_t        exp_q[$];
    logic [16:0] act_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic edge_bit(input logic b, output logic o);
        sclk = 1'b0; sdi = b;
        tick(HALF);
        o = sdo_oe ? sdo : 1'bx;
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic d;
        for (int i = n - 1; i >= 0; i--) edge_bit(v[i], d);
    endtask

    task automatic deselect(input int n);
        sclk = 1'b0; sdi = 1'b0; sel = 1'b0;
        tick(n);
    endtask

    task automatic status(output logic oe, output logic val);
        sel = 1'b1;
        tick(8);
        oe = sdo_oe; val = sdo;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        logic [16:0] w;
        exp_t e;
        e.v = exp; e.tag = tag;
        exp_q.push_back(e);
        sel = 1'b1; tick(2);
        send_bits({23'd0, 1'b1, 2'b10, a}, 9);
        for (int i = 0; i < 17; i++) edge_bit(1'b0, w[16 - i]);
        act_q.push_back(w);
        deselect(30);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        sel = 1'b1; tick(2);
        send_bits({23'd0, 1'b1, 2'b01, a}, 9);
        send_bits({16'd0, d}, 16);
        deselect(30);
    endtask

    task automatic special(input logic [1:0] code);
        sel = 1'b1; tick(2);
        send_bits({23'd0, 1'b1, 2'b00, code, 4'b0000}, 9);
        deselect(30);
    endtask

    // Monitor: pop expected and actual read streams in order and compare.
    initial begin
        forever begin
            @(posedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                automatic logic [16:0] a = act_q.pop_front();
                automatic exp_t e = exp_q.pop_front();
                n_checks++;
                if (a !== {1'b0, e.v}) begin
                    n_fail++;
                    $display("FAIL %s read stream actual=%h expected=%h", e.tag, a, {1'b0, e.v});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        tick(150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic oe, v, d;
        tick(5);
        rst_n = 1'b1;
        tick(40);
        chk("R12", "oe after reset", {31'd0, sdo_oe}, 32'd0);

        // R2: reset contents, read while disabled
        rd(6'd0, 16'hFFFF, "R2");

        // R3: write while disabled has no effect, no status afterwards
        wr(6'd5, 16'h1111);
        status(oe, v);
        chk("R3", "no status when disabled", {31'd0, oe}, 32'd0);
        deselect(30);
        rd(6'd5, 16'hFFFF, "R3");

        // R11: truncated enable frame leaves writes disabled
        sel = 1'b1; tick(2);
        send_bits(32'b10011, 5);
        deselect(30);
        wr(6'd5, 16'h2222);
        rd(6'd5, 16'hFFFF, "R11");

        // R4/R5/R8: enable then write, status busy then ready
        special(2'b11);
        sel = 1'b1; tick(2);
        send_bits({23'd0, 1'b1, 2'b01, 6'd5}, 9);
        chk("R12", "oe during header shift", {31'd0, sdo_oe}, 32'd0);
        send_bits(32'hA5C3, 16);
        deselect(30);
        status(oe, v);
        chk("R8", "status busy oe", {31'd0, oe}, 32'd1);
        chk("R8", "status busy value", {31'd0, v}, 32'd0);
        deselect(30);
        tick(PROG);
        status(oe, v);
        chk("R8", "status ready value", {31'd0, oe & v}, 32'd1);
        // R8: a start bit while ready opens a new frame (read here)
        begin
            logic [16:0] w;
            exp_t e;
            e.v = 16'hA5C3; e.tag = "R5";
            exp_q.push_back(e);
            send_bits({23'd0, 1'b1, 2'b10, 6'd5}, 9);
            for (int i = 0; i < 17; i++) edge_bit(1'b0, w[16 - i]);
            act_q.push_back(w);
            deselect(30);
        end

        // R1: leading zeros before the start bit
        sel = 1'b1; tick(2);
        send_bits({20'd0, 3'b000, 1'b1, 2'b01, 6'd63}, 12);
        send_bits(32'h1234, 16);
        deselect(30);
        // R9: short low interval hides status
        status(oe, v);
        chk("R8", "busy after second write", {30'd0, oe, v}, 32'd2);
        deselect(5);
        status(oe, v);
        chk("R9", "short low undriven", {31'd0, oe}, 32'd0);
        deselect(30);
        // R10: full write frame while busy is lost
        status(oe, v);
        chk("R10", "busy before late frame", {30'd0, oe, v}, 32'd2);
        send_bits({23'd0, 1'b1, 2'b01, 6'd63}, 9);
        send_bits(32'h0F0F, 16);
        deselect(30);
        tick(PROG + 100);
        rd(6'd63, 16'h1234, "R10");
        rd(6'd63, 16'h1234, "R1");

        // R6: single erase
        sel = 1'b1; tick(2);
        send_bits({23'd0, 1'b1, 2'b11, 6'd5}, 9);
        deselect(30);
        tick(PROG + 50);
        rd(6'd5, 16'hFFFF, "R6");
        rd(6'd63, 16'h1234, "R6");

        // R7: whole-array write
        sel = 1'b1; tick(2);
        send_bits({23'd0, 1'b1, 2'b00, 2'b01, 4'b0000}, 9);
        send_bits(32'h5A5A, 16);
        deselect(30);
        tick(PROG + 50);
        rd(6'd0, 16'h5A5A, "R7");
        rd(6'd33, 16'h5A5A, "R7");
        rd(6'd63, 16'h5A5A, "R7");

        // R11: truncated write data leaves word intact
        sel = 1'b1; tick(2);
        send_bits({23'd0, 1'b1, 2'b01, 6'd10}, 9);
        send_bits(32'h3FF, 10);
        deselect(30);
        status(oe, d);
        chk("R11", "no cycle after abort", {31'd0, oe}, 32'd0);
        deselect(30);
        rd(6'd10, 16'h5A5A, "R11");

        // R6: whole-array erase
        special(2'b10);
        tick(PROG + 50);
        rd(6'd7, 16'hFFFF, "R6");

        // R4: disable, then writes are refused; read still works
        special(2'b00);
        wr(6'd3, 16'h0000);
        tick(PROG + 50);
        rd(6'd3, 16'hFFFF, "R4");

        tick(20);
        chk("R12", "oe deselected at end", {31'd0, sdo_oe}, 32'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule